// File: doc/BRIEF.md
# Effective Address Generator

This block forms memory and branch-target addresses for a 16-bit processor that moves data over one shared bus. It is purely combinational: a base operand, either the program counter or a value read from the register file, is added to a second operand. The second operand is zero, a sign-extended 6-bit offset, or a sign-extended 9-bit offset, all taken from the low bits of the instruction register. By the time this block sees the program counter, it has already been incremented. A PC-relative result is therefore relative to the next instruction.

A second multiplexer, on the memory-address side, picks either the adder result or an 8-bit trap-vector number taken from the instruction and zero-extended. A separate enable drives that choice onto the shared bus. When the enable is low, the bus output floats. The raw select lines come from an external control word. A small control module turns them into a struct of one-hot strobes that steers the datapath. The state machine that sequences these selects is outside this block.

Top module: `eag_top`

## Requirements
- R1: With `baseSel` = 0, the base operand is `pcIn`. Because of this, `addrOut` equals `pcIn` when the offset is zero.
- R2: With `baseSel` = 1, the base operand is `regIn`.
- R3: With `offSel` = 2'b00, the second operand is zero, so `addrOut` equals the base operand.
- R4: With `offSel` = 2'b01, the second operand is `irLow[5:0]` read as two's complement and sign-extended to 16 bits.
- R5: With `offSel` = 2'b10, the second operand is `irLow[8:0]` read as two's complement and sign-extended to 16 bits.
- R6: The code `offSel` = 2'b11 is treated as zero offset.
- R7: The sum wraps modulo 2^16, and nothing flags a carry out or an overflow.
- R8: With `marSel` = 0, the memory-side value is the adder result.
- R9: With `marSel` = 1, the memory-side value is `irLow[7:0]` zero-extended to 16 bits.
- R10: With `busEn` = 1, `busOut` carries the memory-side value.
- R11: With `busEn` = 0, every bit of `busOut` is high-impedance.
- R12: `addrOut` depends only on the base and offset selection. `marSel` and `busEn` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcIn | input | 16 | Program counter, already pointing at the next instruction |
| regIn | input | 16 | Register-file read value used as the base register |
| irLow | input | 9 | Instruction register bits 8..0 |
| baseSel | input | 1 | Base select: 0 selects the PC, 1 selects the register |
| offSel | input | 2 | Offset select: 00 zero, 01 6-bit, 10 9-bit, 11 zero |
| marSel | input | 1 | Memory-side select: 0 selects the adder, 1 selects the trap vector |
| busEn | input | 1 | Drives the memory-side value onto the bus |
| addrOut | output | 16 | Adder result |
| busOut | output | 16 | Tri-state bus value |

## Verification
The bench uses offsets whose sign bit is set at exactly the field width: 6'h20, 6'h3F, 9'h100 and 9'h1FF. A design that zero-extends, or that takes the sign from the wrong bit, gives results that are off by 64 or by 512. It places bits 6..8 of the instruction next to a negative 6-bit offset, so that a 6-bit path that leaks the wider field shows up. For the trap vector it sets bit 7 and bit 8 of the instruction, which catches a vector that is sign-extended or takes in bit 8. Sums at 16'hFFFF + 1 and 16'h0000 - 1 check the wrap. Disabled cycles are compared against all-Z, which catches a bus that keeps driving.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int DATA_W = 16;
  localparam int OFF6_W = 6;
  localparam int OFF9_W = 9;
  localparam int VEC_W  = 8;

  typedef enum logic [1:0] {
    OFF_NONE = 2'b00,
    OFF_SIX  = 2'b01,
    OFF_NINE = 2'b10,
    OFF_RSVD = 2'b11
  } offCode_e;

  typedef struct packed {
    logic basePc;
    logic baseReg;
    logic offZero;
    logic offSix;
    logic offNine;
    logic marSum;
    logic marVec;
    logic drive;
  } eagStrobe_t;
endpackage

// File: rtl/eag_sext.sv
module eag_sext #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  fieldIn,
  output logic [OUT_W-1:0] extOut
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign extOut = {{PAD_W{fieldIn[IN_W-1]}}, fieldIn};
    end else begin : g_same
      assign extOut = fieldIn[OUT_W-1:0];
    end
  endgenerate

  always_comb begin
    if (PAD_W > 0 && !$isunknown(fieldIn))
      AST_SEXT_FILL: assert ($countones(extOut[OUT_W-1:IN_W-1]) == 0 ||
                             $countones(extOut[OUT_W-1:IN_W-1]) == PAD_W + 1); // R4
  end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       baseSel,
  input  logic [1:0] offSel,
  input  logic       marSel,
  input  logic       busEn,
  output eagStrobe_t strobe
);
  offCode_e offCode;

  always_comb begin
    offCode        = offCode_e'(offSel);
    strobe         = '0;
    strobe.basePc  = ~baseSel;
    strobe.baseReg = baseSel;
    unique case (offCode)
      OFF_SIX:  strobe.offSix  = 1'b1;
      OFF_NINE: strobe.offNine = 1'b1;
      default:  strobe.offZero = 1'b1;
    endcase
    strobe.marSum  = ~marSel;
    strobe.marVec  = marSel;
    strobe.drive   = busEn;
  end

  always_comb begin
    if (!$isunknown({baseSel, offSel, marSel})) begin
      AST_OFF_ONEHOT: assert ($onehot({strobe.offZero, strobe.offSix, strobe.offNine})); // R6
      AST_BASE_ONEHOT: assert ($onehot({strobe.basePc, strobe.baseReg})); // R1
      AST_MAR_ONEHOT: assert ($onehot({strobe.marSum, strobe.marVec})); // R8
    end
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
(
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] regIn,
  input  logic [OFF9_W-1:0] irLow,
  input  eagStrobe_t        strobe,
  output logic [DATA_W-1:0] sumOut,
  output logic [DATA_W-1:0] marOut
);
  logic [DATA_W-1:0] baseOp;
  logic [DATA_W-1:0] offOp;
  logic [DATA_W-1:0] ext6;
  logic [DATA_W-1:0] ext9;
  logic [DATA_W-1:0] vecExt;

  eag_sext #(.IN_W(OFF6_W), .OUT_W(DATA_W)) u_sext6 (
    .fieldIn(irLow[OFF6_W-1:0]),
    .extOut (ext6)
  );

  eag_sext #(.IN_W(OFF9_W), .OUT_W(DATA_W)) u_sext9 (
    .fieldIn(irLow),
    .extOut (ext9)
  );

  assign vecExt = {{(DATA_W-VEC_W){1'b0}}, irLow[VEC_W-1:0]};

  always_comb begin
    baseOp = ({DATA_W{strobe.basePc}}  & pcIn)
           | ({DATA_W{strobe.baseReg}} & regIn);
    offOp  = ({DATA_W{strobe.offSix}}  & ext6)
           | ({DATA_W{strobe.offNine}} & ext9);
  end

  assign sumOut = baseOp + offOp;

  always_comb begin
    marOut = ({DATA_W{strobe.marSum}} & sumOut)
           | ({DATA_W{strobe.marVec}} & vecExt);
  end

  always_comb begin
    if (!$isunknown({pcIn, regIn, irLow, strobe})) begin
      if (strobe.offZero)
        AST_ZERO_PASS: assert (sumOut == (strobe.basePc ? pcIn : regIn)); // R3
      if (strobe.offSix)
        AST_SIX_LOW: assert (sumOut[OFF6_W-1:0] ==
                             OFF6_W'(baseOp[OFF6_W-1:0] + irLow[OFF6_W-1:0])); // R4
      if (strobe.offNine)
        AST_NINE_LOW: assert (sumOut[OFF9_W-1:0] ==
                              OFF9_W'(baseOp[OFF9_W-1:0] + irLow)); // R5
      if (strobe.marVec)
        AST_VEC_ZEXT: assert (marOut[DATA_W-1:VEC_W] == '0 &&
                              marOut[VEC_W-1:0] == irLow[VEC_W-1:0]); // R9
      if (strobe.marSum)
        AST_MAR_SUM: assert (marOut == sumOut); // R8
    end
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
(
  input  logic [15:0] pcIn,
  input  logic [15:0] regIn,
  input  logic [8:0]  irLow,
  input  logic        baseSel,
  input  logic [1:0]  offSel,
  input  logic        marSel,
  input  logic        busEn,
  output logic [15:0] addrOut,
  output tri   [15:0] busOut
);
  eagStrobe_t        strobe;
  logic [DATA_W-1:0] marVal;

  eag_ctrl u_ctrl (
    .baseSel(baseSel),
    .offSel (offSel),
    .marSel (marSel),
    .busEn  (busEn),
    .strobe (strobe)
  );

  eag_datapath u_dp (
    .pcIn  (pcIn),
    .regIn (regIn),
    .irLow (irLow),
    .strobe(strobe),
    .sumOut(addrOut),
    .marOut(marVal)
  );

  assign busOut = strobe.drive ? marVal : {DATA_W{1'bz}};

  always_comb begin
    if (!$isunknown({marSel, irLow}) && marSel)
      AST_VEC_RANGE: assert (marVal < (1 << VEC_W)); // R9
  end
endmodule

// File: tb/eag_top_bench.sv
module eag_top_bench;
  logic        clk = 1'b0;
  logic [15:0] pcIn = '0;
  logic [15:0] regIn = '0;
  logic [8:0]  irLow = '0;
  logic        baseSel = 1'b0;
  logic [1:0]  offSel = 2'b00;
  logic        marSel = 1'b0;
  logic        busEn = 1'b0;
  logic [15:0] addrOut;
  tri   [15:0] busOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  eag_top u_eag_top (
    .pcIn(pcIn), .regIn(regIn), .irLow(irLow), .baseSel(baseSel),
    .offSel(offSel), .marSel(marSel), .busEn(busEn),
    .addrOut(addrOut), .busOut(busOut)
  );

  function automatic logic [15:0] refAddr(logic [15:0] pc, logic [15:0] rg,
                                           logic [8:0] ir, logic bs, logic [1:0] os);
    logic [15:0] b;
    logic [15:0] o;
    b = bs ? rg : pc;
    case (os)
      2'b01:   o = 16'($signed(ir[5:0]));
      2'b10:   o = 16'($signed(ir));
      default: o = 16'h0000;
    endcase
    return b + o;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] pc, logic [15:0] rg, logic [8:0] ir,
                       logic bs, logic [1:0] os, logic ms, logic be);
    @(negedge clk);
    pcIn = pc; regIn = rg; irLow = ir; baseSel = bs;
    offSel = os; marSel = ms; busEn = be;
    #1;
  endtask

  task automatic testIdle();
    apply(16'h3000, 16'h1234, 9'h000, 1'b0, 2'b00, 1'b0, 1'b0);
    check("R11 idle bus", busOut, 16'hzzzz);
    check("R3 idle addr", addrOut, 16'h3000);
  endtask

  task automatic testBase();
    apply(16'h3001, 16'hBEEF, 9'h000, 1'b0, 2'b00, 1'b0, 1'b1);
    check("R1 pc base", addrOut, 16'h3001);
    check("R10 bus drives sum", busOut, 16'h3001);
    apply(16'h3001, 16'hBEEF, 9'h000, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R2 reg base", addrOut, 16'hBEEF);
  endtask

  task automatic testOff6();
    logic [8:0] irs [4] = '{9'h005, 9'h020, 9'h1FF, 9'h0DF};
    foreach (irs[i]) begin
      apply(16'h4000, 16'h2000, irs[i], 1'b1, 2'b01, 1'b0, 1'b1);
      check("R4 offset6", addrOut, refAddr(16'h4000, 16'h2000, irs[i], 1'b1, 2'b01));
    end
    apply(16'h4000, 16'h2000, 9'h1E0, 1'b1, 2'b01, 1'b0, 1'b1);
    check("R4 offset6 -32", addrOut, 16'h1FE0);
  endtask

  task automatic testOff9();
    apply(16'h3005, 16'h0000, 9'h100, 1'b0, 2'b10, 1'b0, 1'b1);
    check("R5 offset9 -256", addrOut, 16'h2F05);
    apply(16'h3005, 16'h0000, 9'h0FF, 1'b0, 2'b10, 1'b0, 1'b1);
    check("R5 offset9 +255", addrOut, 16'h3104);
    apply(16'h3005, 16'h0000, 9'h1FF, 1'b0, 2'b10, 1'b0, 1'b1);
    check("R5 offset9 -1", addrOut, 16'h3004);
  endtask

  task automatic testRsvd();
    apply(16'h5555, 16'h0000, 9'h1FF, 1'b0, 2'b11, 1'b0, 1'b1);
    check("R6 reserved code zero", addrOut, 16'h5555);
  endtask

  task automatic testWrap();
    apply(16'hFFFF, 16'h0000, 9'h001, 1'b0, 2'b10, 1'b0, 1'b1);
    check("R7 wrap up", addrOut, 16'h0000);
    apply(16'h0000, 16'h0000, 9'h03F, 1'b1, 2'b01, 1'b0, 1'b1);
    check("R7 wrap down", addrOut, 16'hFFFF);
  endtask

  task automatic testVector();
    apply(16'h3000, 16'h0000, 9'h1A5, 1'b0, 2'b10, 1'b1, 1'b1);
    check("R9 vector zext", busOut, 16'h00A5);
    check("R12 addr unaffected by marSel", addrOut, refAddr(16'h3000, 16'h0, 9'h1A5, 1'b0, 2'b10));
    apply(16'h3000, 16'h0000, 9'h025, 1'b0, 2'b10, 1'b0, 1'b1);
    check("R8 mar sum", busOut, 16'h3025);
    apply(16'h3000, 16'h0000, 9'h025, 1'b0, 2'b10, 1'b1, 1'b0);
    check("R11 vector disabled", busOut, 16'hzzzz);
    check("R12 addr unaffected by busEn", addrOut, 16'h3025);
  endtask

  initial begin
    testIdle();
    testBase();
    testOff6();
    testOff9();
    testRsvd();
    testWrap();
    testVector();
    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule